// File: doc/BRIEF.md
# IDE Bus-Master DMA Register File

This block is the host-visible register window of a two-channel IDE bus-master DMA engine. Each channel owns an 8-byte slot in a 16-byte I/O window. Bit 3 of the address selects the channel. Within a slot, the lower four bytes hold a command register and a status register. The upper four bytes hold a 32-bit descriptor-table pointer. The host reaches the window over a simple synchronous bus. That bus carries a byte address, an access size, a write strobe with data, and a read strobe. Read data returns one cycle after the read strobe.

Command and status accept only single-byte accesses: a wider read of that part returns all ones and a wider write is dropped. The status byte combines three kinds of bit. Some bits the host simply writes. Some bits the engine sets and the host clears by writing ones. One bit reports the engine's activity level and cannot be written at all. The block also takes one drive interrupt per channel. It copies each interrupt into a per-channel configuration flag and passes it straight through to a legacy interrupt line.

The DMA data mover attaches through the run, direction and start outputs and through the activity, error and interrupt event inputs.

Top module: `bmdma_regfile`

## Requirements
- R1: While reset is high and on the first cycle after it, every register reads as 0. This covers command, status, pointer and the configuration flags, and `bus_rvalid` is 0.
- R2: A read strobe gives `bus_rvalid` high on the next cycle and low otherwise. Byte reads in the lower half of a slot return, by offset: offset 0 the command byte; offset 2 the status byte; offsets 1 and 3 the value 0xFF. Bits 31:8 of `bus_rdata` are 0. Address bit 3 picks the channel.
- R3: Sizes are encoded 0 = byte, 1 = word, 2 or 3 = dword. A word read of the lower half of a slot returns 0x0000FFFF and a dword read returns 0xFFFFFFFF. Neither read changes any state.
- R4: A write of size other than byte to the lower half of a slot changes neither the command nor the status register.
- R5: A byte write to status offset 2 loads status bits 5 and 6 from the written data.
- R6: Status bit 1 (error) and bit 2 (interrupt) are set by a one-cycle pulse on `eng_err_set` / `eng_irq_set`. A byte write to the status byte clears each of them where the written bit is 1 and keeps it where the written bit is 0. If a set pulse and a clear land in the same cycle, the set wins.
- R7: Status bit 0 shows the level of `eng_active` sampled on the previous clock, and status writes never alter it. Status bits 3, 4 and 7 always read 0.
- R8: A byte write to command offset 0 stores bit 0 (run) and bit 3 (direction); the other command bits read 0. When bit 0 goes from 0 to 1, `dma_start` pulses for exactly one cycle.
- R9: The descriptor pointer at slot offsets 4 to 7 takes byte, word and dword writes. The written byte lanes start at the address offset, and lanes past byte 3 are dropped. Pointer bits 1:0 always read 0. A pointer read returns the pointer shifted right by 8 times the offset, masked to the access width.
- R10: `cfg_irq_flag[n]` equals the level of `drive_irq[n]` on the previous clock.
- R11: `legacy_irq[n]` (legacy line 14+n) follows `drive_irq[n]` at the same level with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address in the window |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, lane 0 at the addressed byte |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| eng_active | input | 2 | Per-channel engine busy level |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |
| drive_irq | input | 2 | Per-channel drive interrupt |
| cfg_irq_flag | output | 2 | Per-channel configuration interrupt flag |
| legacy_irq | output | 2 | Legacy interrupt lines 14 and 15 |
| dma_start | output | 2 | One-cycle start pulse per channel |
| dma_run | output | 2 | Command run bit per channel |
| dma_dir | output | 2 | Command direction bit per channel |

## Verification
The assertions cover the timing relations that must hold on every cycle:
- read valid follows the strobe by one cycle;
- the start pulse only accompanies a 0-to-1 change of the run bit;
- the activity bit and the configuration flag copy their inputs with one cycle of lag;
- a set pulse always wins over a clear;
- a wide write never moves the command register.

The bench's scenarios are needed for the decode itself. They show the all-ones values for wide reads, the 0xFF fill bytes, the exact clear-by-one mask of the status write, the lane placement of partial pointer writes, and the fact that wide status writes and all reads leave state untouched.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned SLOT_B  = 8;
    localparam int unsigned DATA_W  = 32;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWX   = 2'd3
    } acc_size_e;

    // status byte bit positions
    localparam int unsigned ST_ACT = 0;
    localparam int unsigned ST_ERR = 1;
    localparam int unsigned ST_INT = 2;
    localparam int unsigned ST_U5  = 5;
    localparam int unsigned ST_U6  = 6;

    // command byte bit positions
    localparam int unsigned CM_RUN = 0;
    localparam int unsigned CM_DIR = 3;

    typedef struct packed {
        logic       u6;
        logic       u5;
        logic       intr;
        logic       err;
        logic       act;
    } status_t;

    function automatic logic [7:0] status_byte(input status_t s);
        logic [7:0] b;
        b          = 8'h00;
        b[ST_ACT]  = s.act;
        b[ST_ERR]  = s.err;
        b[ST_INT]  = s.intr;
        b[ST_U5]   = s.u5;
        b[ST_U6]   = s.u6;
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] lane_enables(input logic [1:0] sz,
                                                input logic [1:0] off);
        logic [6:0] base;
        case (sz)
            SZ_BYTE: base = 7'b000_0001;
            SZ_WORD: base = 7'b000_0011;
            default: base = 7'b000_1111;
        endcase
        base = base << off;
        return base[3:0];
    endfunction

endpackage

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              sts_we,
    input  logic [3:0]        ptr_be,
    input  logic [7:0]        wr_byte,
    input  logic [DATA_W-1:0] ptr_wdata,
    input  logic              eng_active,
    input  logic              err_set,
    input  logic              int_set,
    output logic [7:0]        cmd_byte,
    output logic [7:0]        sts_byte,
    output logic [DATA_W-1:0] ptr_val,
    output logic              start_pulse,
    output logic              run,
    output logic              dir
);

    logic              run_q, dir_q, start_q;
    status_t           st_q;
    logic [DATA_W-1:2] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            dir_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= cmd_we && wr_byte[CM_RUN] && !run_q;
            if (cmd_we) begin
                run_q <= wr_byte[CM_RUN];
                dir_q <= wr_byte[CM_DIR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.act <= eng_active;
            if (err_set)
                st_q.err <= 1'b1;
            else if (sts_we && wr_byte[ST_ERR])
                st_q.err <= 1'b0;
            if (int_set)
                st_q.intr <= 1'b1;
            else if (sts_we && wr_byte[ST_INT])
                st_q.intr <= 1'b0;
            if (sts_we) begin
                st_q.u5 <= wr_byte[ST_U5];
                st_q.u6 <= wr_byte[ST_U6];
            end
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_lane
        localparam int unsigned LO = (i == 0) ? 2 : 8 * i;
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[8*i+7:LO] <= '0;
            else if (ptr_be[i])
                ptr_q[8*i+7:LO] <= ptr_wdata[8*i+7:LO];
        end
    end

    always_comb begin
        cmd_byte         = 8'h00;
        cmd_byte[CM_RUN] = run_q;
        cmd_byte[CM_DIR] = dir_q;
        sts_byte         = status_byte(st_q);
        ptr_val          = {ptr_q, 2'b00};
    end

    assign start_pulse = start_q;
    assign run         = run_q;
    assign dir         = dir_q;

    AST_ACT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sts_byte[ST_ACT] == $past(eng_active)); // R7
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
        (sts_we && wr_byte[ST_ERR] && !err_set) |=> !sts_byte[ST_ERR]); // R6
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        err_set |=> sts_byte[ST_ERR]); // R6
    AST_INT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        int_set |=> sts_byte[ST_INT]); // R6
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (cmd_byte[CM_RUN] && !$past(cmd_byte[CM_RUN]))); // R8
    AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R8

endmodule

// File: rtl/bmdma_rd_mux.sv
module bmdma_rd_mux
    import bmdma_pkg::*;
#(
    parameter int unsigned CH   = NUM_CH,
    parameter int unsigned AW   = 4,
    localparam int unsigned CW  = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd,
    input  logic [AW-1:0]              addr,
    input  logic [1:0]                 size,
    input  logic [CH-1:0][7:0]         cmd_b,
    input  logic [CH-1:0][7:0]         sts_b,
    input  logic [CH-1:0][DATA_W-1:0]  ptr_v,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rvalid
);

    logic [CW-1:0]       ch;
    logic [1:0]          off;
    logic [DATA_W-1:0]   nxt;

    assign ch  = addr[AW-1:3];
    assign off = addr[1:0];

    always_comb begin
        nxt = '0;
        if (addr[2]) begin
            nxt = (ptr_v[ch] >> {off, 3'b000}) & size_mask(size);
        end else if (size != SZ_BYTE) begin
            nxt = size_mask(size);
        end else begin
            case (off)
                2'd0:    nxt = {24'h0, cmd_b[ch]};
                2'd2:    nxt = {24'h0, sts_b[ch]};
                default: nxt = 32'h0000_00FF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd)
                rdata <= nxt;
        end
    end

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid); // R2
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid); // R2

endmodule

// File: rtl/bmdma_irq_mirror.sv
module bmdma_irq_mirror #(
    parameter int unsigned CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] irq_in,
    output logic [CH-1:0] flag,
    output logic [CH-1:0] legacy
);

    for (genvar n = 0; n < CH; n++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                flag[n] <= 1'b0;
            else
                flag[n] <= irq_in[n];
        end
        assign legacy[n] = irq_in[n];

        AST_FLAG_MIRROR: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> flag[n] == $past(irq_in[n])); // R10
    end

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [1:0]        eng_active,
    input  logic [1:0]        eng_err_set,
    input  logic [1:0]        eng_irq_set,
    input  logic [1:0]        drive_irq,
    output logic [1:0]        cfg_irq_flag,
    output logic [1:0]        legacy_irq,
    output logic [1:0]        dma_start,
    output logic [1:0]        dma_run,
    output logic [1:0]        dma_dir
);

    localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned AW = CW + $clog2(SLOT_B);

    logic [CW-1:0]               wr_ch;
    logic [1:0]                  wr_off;
    logic                        in_cs, is_byte;
    logic [3:0]                  lanes;
    logic [DATA_W-1:0]           aligned;
    logic [NUM_CH-1:0][7:0]      cmd_b, sts_b;
    logic [NUM_CH-1:0][DATA_W-1:0] ptr_v;

    assign wr_ch   = bus_addr[AW-1:3];
    assign wr_off  = bus_addr[1:0];
    assign in_cs   = !bus_addr[2];
    assign is_byte = (bus_size == SZ_BYTE);
    assign lanes   = lane_enables(bus_size, wr_off);
    assign aligned = bus_wdata << {wr_off, 3'b000};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic       sel, cmd_we, sts_we;
        logic [3:0] be;

        assign sel    = bus_wr && (wr_ch == CW'(c));
        assign cmd_we = sel && in_cs && is_byte && (wr_off == 2'd0);
        assign sts_we = sel && in_cs && is_byte && (wr_off == 2'd2);
        assign be     = (sel && !in_cs) ? lanes : 4'b0000;

        bmdma_chan_regs u_chan (
            .clk         (clk),
            .rst         (rst),
            .cmd_we      (cmd_we),
            .sts_we      (sts_we),
            .ptr_be      (be),
            .wr_byte     (bus_wdata[7:0]),
            .ptr_wdata   (aligned),
            .eng_active  (eng_active[c]),
            .err_set     (eng_err_set[c]),
            .int_set     (eng_irq_set[c]),
            .cmd_byte    (cmd_b[c]),
            .sts_byte    (sts_b[c]),
            .ptr_val     (ptr_v[c]),
            .start_pulse (dma_start[c]),
            .run         (dma_run[c]),
            .dir         (dma_dir[c])
        );

        AST_WIDE_WR_DROP: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && in_cs && !is_byte && wr_ch == CW'(c)) |=> $stable(cmd_b[c])); // R4
    end

    bmdma_rd_mux #(.CH(NUM_CH), .AW(AW)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .size   (bus_size),
        .cmd_b  (cmd_b),
        .sts_b  (sts_b),
        .ptr_v  (ptr_v),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    bmdma_irq_mirror #(.CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .irq_in (drive_irq),
        .flag   (cfg_irq_flag),
        .legacy (legacy_irq)
    );

endmodule

// File: tb/tb_bmdma_regfile.sv
module tb_bmdma_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [1:0]  bus_size;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  eng_active, eng_err_set, eng_irq_set, drive_irq;
    logic [1:0]  cfg_irq_flag, legacy_irq, dma_start, dma_run, dma_dir;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bmdma_regfile dut (.*);

    // reference model
    bit          m_run[2], m_dir[2], m_s5[2], m_s6[2], m_err[2], m_int[2], m_act[2];
    logic [31:0] m_ptr[2];

    function automatic logic [31:0] wmask(input logic [1:0] sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [7:0] exp_sts(input int c);
        return {1'b0, m_s6[c], m_s5[c], 2'b00, m_int[c], m_err[c], m_act[c]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
        int c = a[3];
        if (a[2]) return (m_ptr[c] >> (8 * a[1:0])) & wmask(sz);
        if (sz != 0) return wmask(sz);
        case (a[1:0])
            2'd0:    return {24'h0, 4'b0, m_dir[c], 2'b00, m_run[c]};
            2'd2:    return {24'h0, exp_sts(c)};
            default: return 32'hFF;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit rd, input bit wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [1:0] act, input logic [1:0] es,
                        input logic [1:0] is, input logic [1:0] irq);
        logic [31:0] exp_rd;
        logic [1:0]  exp_pulse;
        string       rq;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        eng_active = act; eng_err_set = es; eng_irq_set = is; drive_irq = irq;
        exp_rd    = exp_read(a, sz);
        exp_pulse = 2'b00;
        for (int c = 0; c < 2; c++) begin
            bit cw = wr && (a[3] == c) && !a[2] && sz == 0 && a[1:0] == 0;
            bit sw = wr && (a[3] == c) && !a[2] && sz == 0 && a[1:0] == 2;
            if (cw) begin
                exp_pulse[c] = wd[0] && !m_run[c];
                m_run[c] = wd[0]; m_dir[c] = wd[3];
            end
            if (es[c]) m_err[c] = 1; else if (sw && wd[1]) m_err[c] = 0;
            if (is[c]) m_int[c] = 1; else if (sw && wd[2]) m_int[c] = 0;
            if (sw) begin m_s5[c] = wd[5]; m_s6[c] = wd[6]; end
            m_act[c] = act[c];
            if (wr && (a[3] == c) && a[2]) begin
                for (int l = 0; l < 4; l++) begin
                    int src = l - a[1:0];
                    if (src >= 0 && src < ((sz == 0) ? 1 : (sz == 1) ? 2 : 4))
                        m_ptr[c][8*l +: 8] = wd[8*src +: 8];
                end
                m_ptr[c][1:0] = 2'b00;
            end
        end
        #0;
        check("R11 legacy irq", {30'h0, legacy_irq}, {30'h0, irq});
        @(posedge clk);
        #1;
        if (rd) begin
            rq = a[2] ? "R9 ptr read" : (sz != 0) ? "R3 wide read" : "R2 byte read";
            check(rq, bus_rdata, exp_rd);
        end
        check("R2 rvalid", {31'h0, bus_rvalid}, {31'h0, rd});
        check("R8 start pulse", {30'h0, dma_start}, {30'h0, exp_pulse});
        check("R10 cfg flag", {30'h0, cfg_irq_flag}, {30'h0, irq});
    endtask

    task automatic rd_chk(input logic [3:0] a);
        step(1, 0, a, 0, 0, 2'b00, 2'b00, 2'b00, 2'b00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1DE5));
        for (int c = 0; c < 2; c++) begin
            m_run[c] = 0; m_dir[c] = 0; m_s5[c] = 0; m_s6[c] = 0;
            m_err[c] = 0; m_int[c] = 0; m_act[c] = 0; m_ptr[c] = 0;
        end
        rst = 1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
        eng_active = 0; eng_err_set = 0; eng_irq_set = 0; drive_irq = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rvalid", {31'h0, bus_rvalid}, 32'h0);
        check("R1 reset flag", {30'h0, cfg_irq_flag}, 32'h0);
        @(negedge clk); rst = 0;
        // R1: all registers read zero after reset
        rd_chk(4'h0); rd_chk(4'h2); rd_chk(4'h4); rd_chk(4'hA); rd_chk(4'hC);
        // R2: filler offsets
        rd_chk(4'h1); rd_chk(4'hB);
        // R3: wide reads
        step(1, 0, 4'h0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 4'hA, 2, 0, 0, 0, 0, 0);
        step(1, 0, 4'h2, 3, 0, 0, 0, 0, 0);
        // R6: set error/interrupt, then W1C only error, then set-wins
        step(0, 0, 0, 0, 0, 2'b11, 2'b01, 2'b01, 0);
        rd_chk(4'h2);
        step(0, 1, 4'h2, 0, 32'h62, 2'b11, 0, 0, 0); // R5 bits 5,6; R6 clear err; R7 act kept
        rd_chk(4'h2);
        step(0, 1, 4'h2, 0, 32'h06, 2'b01, 2'b01, 0, 0); // R6 set wins over clear
        rd_chk(4'h2);
        // R4: wide writes to status/command dropped
        step(0, 1, 4'h2, 1, 32'hFFFF, 0, 0, 0, 0);
        step(0, 1, 4'h0, 2, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd_chk(4'h2); rd_chk(4'h0);
        // R8: start pulse on rising run, none on re-write
        step(0, 1, 4'h8, 0, 32'hFF, 0, 0, 0, 0);
        step(0, 1, 4'h8, 0, 32'h09, 0, 0, 0, 0);
        rd_chk(4'h8);
        // R9: pointer lanes
        step(0, 1, 4'h4, 2, 32'h1234_5677, 0, 0, 0, 0);
        step(0, 1, 4'h6, 2, 32'hAABB_CCDD, 0, 0, 0, 0);
        step(1, 0, 4'h4, 2, 0, 0, 0, 0, 0);
        step(1, 0, 4'h5, 1, 0, 0, 0, 0, 0);
        // R10/R11: irq mirror
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'b10);
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'b01);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            step(r[0], r[1] && r[2], 4'($urandom), 2'($urandom), $urandom,
                 2'($urandom), (r[5:4] == 0) ? 2'($urandom) : 2'b00,
                 (r[7:6] == 0) ? 2'($urandom) : 2'b00, 2'($urandom));
        end
        for (int a = 0; a < 16; a++) rd_chk(4'(a));
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule